// File: doc/BRIEF.md
# Byte-Command SPI Master with Register Access

This block is an SPI master driven by a processor through a small 32-bit register bus. Every command moves exactly one byte over a half-duplex link. To send, software loads a byte into the data register and sets the write-start bit. The byte is then shifted out on the serial output, and the serial input is ignored. To receive, software sets the read-start bit. Eight bits are then sampled from the serial input and placed in the same data register. Software polls a busy flag in the status register to learn when the command has finished.

The configuration register sets the following:
- a 3-bit power-of-two clock divider, with one code that halts the serial clock;
- the idle level of the serial clock;
- whether data is launched on the rising or the falling serial-clock edge;
- whether data is captured on the rising or the falling serial-clock edge, chosen separately from the launch edge;
- bit order;
- chip-select polarity.

A held enable bit in the control register keeps the chip select asserted, so a device can be kept selected across several byte commands.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, every register reads zero. SCK is low, chip select is high (deasserted) and MOSI is low. Register offsets are: status 0x00, config 0x10, control 0x14, data 0x20. Reads of any other offset return zero.
- R2: A start command is a write to control with bit 2 or bit 1 set while status bit 0 (busy) is low. Busy is high from the clock edge that accepts the start and stays high for 16·2^n clock cycles, where n is config bits [2:0].
- R3: Config bits [2:0] hold a code n. For n from 0 to 6, SCK toggles once every 2^n clock cycles during a command, which divides the clock by 2^(n+1). Code 7 stops SCK: busy stays high and SCK holds its level until the code is changed.
- R4: A write (control bit 2) drives the 8 bits of data[7:0] on MOSI. The first bit appears when the start is accepted. The data register is left unchanged and MISO has no effect. MOSI is low whenever no write is in progress.
- R5: A read (control bit 1) samples MISO on 8 receive edges. The assembled byte is loaded into data[7:0], with bits [31:8] reading zero, on the same edge that busy falls.
- R6: Control bit 0 is a held enable. While it is set, chip select is asserted without interruption across consecutive commands.
- R7: Config bit 16 set makes chip select active-high. When it is clear, chip select is active-low.
- R8: Config bit 8 set sends and assembles the byte MSB first. When it is clear, the byte is sent and assembled LSB first.
- R9: Config bit 6 sets the idle level of SCK. After 16 toggles SCK always ends at that level.
- R10: Config bit 5 set captures MISO on falling SCK edges, and clear captures on rising edges. Config bit 4 set advances MOSI on falling SCK edges, and clear advances on rising edges. MOSI advances at most 7 times per byte. When the two edge types coincide, the capture takes the old MISO value in the same cycle as MOSI advances.
- R11: Control bits 1 and 2 are self-clearing and read back as zero. A start written while busy is high is ignored. If both start bits are set, the command is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from address |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 1 | Chip select, polarity set by config bit 16 |

## Verification
Results fall due at these points, counting from the clock edge that samples a start write (edge E0):
- Busy and the first MOSI bit are visible right after E0.
- SCK toggle k lands on edge E0 + k·2^n.
- Busy clears on edge E0 + 16·2^n, and the received byte is loaded into the data register on that same edge.
- Config and control writes take effect on the edge that samples them.

The bench keeps a behavioural model built from queues of pending MOSI bits and captured MISO bits. It advances that model on the same rising edge as the design and compares SCK, MOSI, chip select and every register read at the following falling edge. Busy durations are counted one read per cycle, starting right after the start write. With that count, a start written mid-command must leave the total at exactly 16·2^n.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

   localparam int DIV_W = 3;

   localparam int OFF_STATUS = 'h00;
   localparam int OFF_CFG    = 'h10;
   localparam int OFF_CTL    = 'h14;
   localparam int OFF_DATA   = 'h20;

   localparam int CFG_CS_HIGH = 16;
   localparam int CFG_MSB     = 8;
   localparam int CFG_CPOL    = 6;
   localparam int CFG_RX_FALL = 5;
   localparam int CFG_TX_FALL = 4;

   localparam int CTL_EN = 0;
   localparam int CTL_RD = 1;
   localparam int CTL_WR = 2;

   typedef struct packed {
      logic             cs_high;
      logic             msb_first;
      logic             cpol;
      logic             rx_fall;
      logic             tx_fall;
      logic [DIV_W-1:0] div;
   } spi_cfg_t;

endpackage

// File: rtl/spi_mm_clkgen.sv
module spi_mm_clkgen #(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int STOP_CODE = (1 << DIV_W) - 1;
   localparam int MAX_SHIFT = STOP_CODE - 1;
   localparam int CNT_W     = MAX_SHIFT + 1;

   generate
      if (DIV_W < 1 || DIV_W > 4) begin : g_bad_div
         $error("spi_mm_clkgen: DIV_W must be 1..4");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_m1;
   logic             stopped;

   assign stopped = (div == DIV_W'(STOP_CODE));
   assign half_m1 = (CNT_W'(1) << div) - CNT_W'(1);
   assign tick    = run && !stopped && (cnt_q >= half_m1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || stopped || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/spi_mm_shifter.sv
module spi_mm_shifter #(
   parameter int FRAME_BITS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_wr,
   input  logic                  start_rd,
   input  logic                  tick,
   input  logic                  cpol,
   input  logic                  tx_fall,
   input  logic                  rx_fall,
   input  logic                  msb_first,
   input  logic [FRAME_BITS-1:0] tx_byte,
   input  logic                  miso,
   output logic                  busy,
   output logic                  sck,
   output logic                  mosi,
   output logic                  rx_done,
   output logic [FRAME_BITS-1:0] rx_byte
);
   localparam int ADV_W  = $clog2(FRAME_BITS);
   localparam int TOG_W  = $clog2(2 * FRAME_BITS) + 1;
   localparam int LAST_T = 2 * FRAME_BITS - 1;

   generate
      if (FRAME_BITS < 2) begin : g_bad_frame
         $error("spi_mm_shifter: FRAME_BITS must be at least 2");
      end
   endgenerate

   logic                  busy_q, wr_q, sck_q;
   logic [FRAME_BITS-1:0] txq, rxq, rx_next, tx_rev, rx_rev;
   logic [ADV_W-1:0]      adv_q;
   logic [TOG_W-1:0]      tog_q;
   logic                  sck_n, tx_edge, rx_edge, last;

   genvar i;
   generate
      for (i = 0; i < FRAME_BITS; i++) begin : g_rev
         assign tx_rev[i] = tx_byte[FRAME_BITS-1-i];
         assign rx_rev[i] = rx_next[FRAME_BITS-1-i];
      end
   endgenerate

   assign sck_n   = ~sck_q;
   assign tx_edge = tick & (sck_n ^ tx_fall);
   assign rx_edge = tick & (sck_n ^ rx_fall);
   assign last    = tick && (tog_q == TOG_W'(LAST_T));
   assign rx_next = rx_edge ? {rxq[FRAME_BITS-2:0], miso} : rxq;

   assign busy    = busy_q;
   assign sck     = sck_q;
   assign mosi    = busy_q & wr_q & txq[FRAME_BITS-1];
   assign rx_done = last & ~wr_q;
   assign rx_byte = msb_first ? rx_next : rx_rev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wr_q   <= 1'b0;
         sck_q  <= 1'b0;
         txq    <= '0;
         rxq    <= '0;
         adv_q  <= '0;
         tog_q  <= '0;
      end else if (!busy_q) begin
         sck_q <= cpol;
         if (start_wr || start_rd) begin
            busy_q <= 1'b1;
            wr_q   <= start_wr;
            txq    <= msb_first ? tx_byte : tx_rev;
            rxq    <= '0;
            adv_q  <= '0;
            tog_q  <= '0;
         end
      end else if (tick) begin
         sck_q <= last ? cpol : sck_n;
         tog_q <= tog_q + TOG_W'(1);
         rxq   <= rx_next;
         if (tx_edge && adv_q != ADV_W'(FRAME_BITS - 1)) begin
            txq   <= txq << 1;
            adv_q <= adv_q + ADV_W'(1);
         end
         if (last) begin
            busy_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/spi_mm_regs.sv
module spi_mm_regs
   import spi_mm_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int FRAME_BITS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_we,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic                  busy,
   input  logic                  rx_done,
   input  logic [FRAME_BITS-1:0] rx_byte,
   output spi_cfg_t              cfg,
   output logic                  enable,
   output logic                  start_wr,
   output logic                  start_rd,
   output logic [FRAME_BITS-1:0] tx_byte
);
   generate
      if (DATA_W <= CFG_CS_HIGH || FRAME_BITS > DATA_W) begin : g_bad_width
         $error("spi_mm_regs: DATA_W too narrow for the register layout");
      end
   endgenerate

   spi_cfg_t              cfg_q;
   logic                  en_q;
   logic [FRAME_BITS-1:0] data_q;
   logic                  wr_hit, rd_hit;
   logic                  wr_cfg, wr_ctl, wr_data;
   logic                  wdata_unused;

   assign wr_hit  = bus_sel & bus_we;
   assign rd_hit  = bus_sel & ~bus_we;
   assign wr_cfg  = wr_hit && (bus_addr == ADDR_W'(OFF_CFG));
   assign wr_ctl  = wr_hit && (bus_addr == ADDR_W'(OFF_CTL));
   assign wr_data = wr_hit && (bus_addr == ADDR_W'(OFF_DATA));

   assign start_wr = wr_ctl & bus_wdata[CTL_WR] & ~busy;
   assign start_rd = wr_ctl & bus_wdata[CTL_RD] & ~bus_wdata[CTL_WR] & ~busy;

   assign cfg     = cfg_q;
   assign enable  = en_q;
   assign tx_byte = data_q;
   assign wdata_unused = &{1'b0, bus_wdata};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         en_q   <= 1'b0;
         data_q <= '0;
      end else begin
         if (wr_cfg) begin
            cfg_q.div       <= bus_wdata[DIV_W-1:0];
            cfg_q.tx_fall   <= bus_wdata[CFG_TX_FALL];
            cfg_q.rx_fall   <= bus_wdata[CFG_RX_FALL];
            cfg_q.cpol      <= bus_wdata[CFG_CPOL];
            cfg_q.msb_first <= bus_wdata[CFG_MSB];
            cfg_q.cs_high   <= bus_wdata[CFG_CS_HIGH];
         end
         if (wr_ctl) begin
            en_q <= bus_wdata[CTL_EN];
         end
         if (rx_done) begin
            data_q <= rx_byte;
         end else if (wr_data) begin
            data_q <= bus_wdata[FRAME_BITS-1:0];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_hit) begin
         case (bus_addr)
            ADDR_W'(OFF_STATUS): bus_rdata[0] = busy;
            ADDR_W'(OFF_CFG): begin
               bus_rdata[DIV_W-1:0]   = cfg_q.div;
               bus_rdata[CFG_TX_FALL] = cfg_q.tx_fall;
               bus_rdata[CFG_RX_FALL] = cfg_q.rx_fall;
               bus_rdata[CFG_CPOL]    = cfg_q.cpol;
               bus_rdata[CFG_MSB]     = cfg_q.msb_first;
               bus_rdata[CFG_CS_HIGH] = cfg_q.cs_high;
            end
            ADDR_W'(OFF_CTL):  bus_rdata[CTL_EN] = en_q;
            ADDR_W'(OFF_DATA): bus_rdata[FRAME_BITS-1:0] = data_q;
            default: bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
   import spi_mm_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int FRAME_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs
);
   spi_cfg_t              cfg;
   logic                  enable, start_wr, start_rd, busy, tick, rx_done;
   logic                  cfg_cpol;
   logic [DIV_W-1:0]      cfg_div;
   logic [FRAME_BITS-1:0] tx_byte, rx_byte;

   assign cfg_cpol = cfg.cpol;
   assign cfg_div  = cfg.div;

   spi_mm_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .rx_done(rx_done), .rx_byte(rx_byte),
      .cfg(cfg), .enable(enable), .start_wr(start_wr),
      .start_rd(start_rd), .tx_byte(tx_byte)
   );

   spi_mm_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(busy), .div(cfg_div), .tick(tick)
   );

   spi_mm_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .start_wr(start_wr), .start_rd(start_rd), .tick(tick),
      .cpol(cfg_cpol), .tx_fall(cfg.tx_fall), .rx_fall(cfg.rx_fall),
      .msb_first(cfg.msb_first), .tx_byte(tx_byte), .miso(spi_miso),
      .busy(busy), .sck(spi_sck), .mosi(spi_mosi),
      .rx_done(rx_done), .rx_byte(rx_byte)
   );

   assign spi_cs = cfg.cs_high ? enable : ~enable;

endmodule

// File: rtl/spi_mm_chk.sv
module spi_mm_chk
   import spi_mm_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int FRAME_BITS = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_sel,
   input logic                  bus_we,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [1:0]            start_bits,
   input logic                  spi_sck,
   input logic                  busy,
   input logic                  cpol,
   input logic [DIV_W-1:0]      div,
   input logic                  rx_done,
   input logic [FRAME_BITS-1:0] rx_byte,
   input logic [FRAME_BITS-1:0] data_reg
);
   logic start_req;
   assign start_req = bus_sel && bus_we && (bus_addr == ADDR_W'(OFF_CTL)) && (|start_bits);

   // R2: an accepted start raises busy on the next edge
   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !busy) |=> busy);

   // R3: stop code freezes the serial clock
   p_stop_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && div == DIV_W'((1 << DIV_W) - 1)) |=> $stable(spi_sck));

   // R9: idle clock follows the polarity setting
   p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy) && $stable(cpol)) |-> (spi_sck == cpol));

   // R9: a command ends with the clock at its idle level
   p_end_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (spi_sck == $past(cpol)));

   // R5: received byte lands in the data register
   p_rx_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> (data_reg == $past(rx_byte)));

endmodule

bind spi_byte_master spi_mm_chk #(
   .ADDR_W(ADDR_W), .FRAME_BITS(FRAME_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_addr(bus_addr), .start_bits(bus_wdata[2:1]), .spi_sck(spi_sck),
   .busy(busy), .cpol(cfg_cpol), .div(cfg_div), .rx_done(rx_done),
   .rx_byte(rx_byte), .data_reg(tx_byte)
);

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        spi_sck, spi_mosi, spi_cs;
   logic        spi_miso = 1'b0;

   always #4 clk = ~clk;

   spi_byte_master u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs(spi_cs)
   );

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   // behavioural reference state
   int m_busy, m_wr, m_cnt, m_tog, m_sck, m_en, m_csh, m_msb, m_cpol, m_rxf, m_txf, m_div;
   logic [7:0] m_data;
   bit txq[$];
   bit rxq[$];

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_reg(input logic [7:0] a);
      logic [31:0] r = '0;
      case (a)
         8'h00: r[0] = m_busy[0];
         8'h10: begin
            r[2:0] = m_div[2:0]; r[4] = m_txf[0]; r[5] = m_rxf[0];
            r[6] = m_cpol[0]; r[8] = m_msb[0]; r[16] = m_csh[0];
         end
         8'h14: r[0] = m_en[0];
         8'h20: r[7:0] = m_data;
         default: r = '0;
      endcase
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_wr = 0; m_cnt = 0; m_tog = 0; m_sck = 0; m_en = 0;
         m_csh = 0; m_msb = 0; m_cpol = 0; m_rxf = 0; m_txf = 0; m_div = 0;
         m_data = '0; txq.delete(); rxq.delete();
      end else begin
         int ob;
         bit done;
         ob = m_busy; done = 0;
         if (m_busy != 0) begin
            if (m_div == 7) m_cnt = 0;
            else if (m_cnt >= (1 << m_div) - 1) begin
               m_cnt = 0;
               m_sck = (m_sck == 0) ? 1 : 0;
               m_tog++;
               if (m_sck != m_txf && txq.size() > 1) void'(txq.pop_front());
               if (m_sck != m_rxf) rxq.push_back(spi_miso);
               if (m_tog == 16) begin
                  m_busy = 0;
                  m_sck = m_cpol;
                  if (m_wr == 0) begin
                     for (int i = 0; i < 8; i++)
                        if (m_msb != 0) m_data[7-i] = rxq[i];
                        else m_data[i] = rxq[i];
                     done = 1;
                  end
               end
            end else m_cnt++;
         end else m_sck = m_cpol;
         if (bus_sel && bus_we) begin
            case (bus_addr)
               8'h10: begin
                  m_div = bus_wdata[2:0]; m_txf = bus_wdata[4]; m_rxf = bus_wdata[5];
                  m_cpol = bus_wdata[6]; m_msb = bus_wdata[8]; m_csh = bus_wdata[16];
               end
               8'h14: begin
                  m_en = bus_wdata[0];
                  if (ob == 0 && (bus_wdata[2] || bus_wdata[1])) begin
                     m_busy = 1; m_wr = bus_wdata[2]; m_cnt = 0; m_tog = 0;
                     txq.delete(); rxq.delete();
                     for (int i = 0; i < 8; i++)
                        txq.push_back((m_msb != 0) ? m_data[7-i] : m_data[i]);
                  end
               end
               8'h20: if (!done) m_data = bus_wdata[7:0];
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3/R9/R10", "sck", {31'b0, spi_sck}, {31'b0, m_sck[0]});
         chk("R4/R8/R10", "mosi", {31'b0, spi_mosi},
             {31'b0, (m_busy != 0 && m_wr != 0) ? txq[0] : 1'b0});
         chk("R6/R7", "cs", {31'b0, spi_cs},
             {31'b0, (m_csh != 0) ? m_en[0] : ~m_en[0]});
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      forever begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         spi_miso = lfsr[0];
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic rd(input logic [7:0] a, input string req, output logic [31:0] v);
      bus_sel = 1; bus_we = 0; bus_addr = a;
      #1;
      v = bus_rdata;
      chk(req, "register read", v, exp_reg(a));
      @(negedge clk);
      bus_sel = 0;
   endtask

   // start a command and count cycles with busy high; optionally try a second start mid-command
   task automatic run_xfer(input logic [31:0] ctl, input int half, input bit inject, input string req);
      logic [31:0] v;
      int cnt = 0;
      wr(8'h14, ctl);
      forever begin
         if (inject && cnt == 2) begin
            rd(8'h14, "R11", v);
            chk("R11", "start bits read back", v, {31'b0, ctl[0]});
            cnt++;
         end else if (inject && cnt == 3) begin
            wr(8'h14, ctl);
            cnt++;
         end else begin
            rd(8'h00, "R2", v);
            if (!v[0]) break;
            cnt++;
            if (cnt > 5000) break;
         end
      end
      chk(req, "busy length", cnt, 16 * half);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      begin
         logic [31:0] v;
         logic        s0;
         // R1 reset state
         rd(8'h00, "R1", v); chk("R1", "status", v, 0);
         rd(8'h10, "R1", v); chk("R1", "config", v, 0);
         rd(8'h14, "R1", v); chk("R1", "control", v, 0);
         rd(8'h20, "R1", v); chk("R1", "data", v, 0);
         rd(8'h44, "R1", v); chk("R1", "unmapped", v, 0);
         chk("R1", "sck idle", {31'b0, spi_sck}, 0);
         chk("R1", "cs idle", {31'b0, spi_cs}, 1);
         chk("R1", "mosi idle", {31'b0, spi_mosi}, 0);

         // R4/R2/R11 write, MSB first, divide by 2, with an ignored second start
         wr(8'h10, 32'h100);
         wr(8'h20, 32'hA5);
         wr(8'h14, 32'h1);
         chk("R6", "cs asserted", {31'b0, spi_cs}, 0);
         run_xfer(32'h5, 1, 1, "R2");
         rd(8'h20, "R4", v); chk("R4", "data kept after write", v, 32'hA5);

         // R6 back-to-back command keeps select
         wr(8'h20, 32'h3C);
         run_xfer(32'h5, 1, 0, "R2");
         chk("R6", "cs still asserted", {31'b0, spi_cs}, 0);

         // R5 read, divide by 4, capture on falling edge
         wr(8'h10, 32'h121);
         run_xfer(32'h3, 2, 0, "R2");
         rd(8'h20, "R5", v);
         chk("R5", "upper data bits", {24'b0, v[31:8]}, 0);
         wr(8'h14, 32'h0);
         chk("R6", "cs released", {31'b0, spi_cs}, 1);

         // R8/R9/R10 LSB first, idle high, launch on falling
         wr(8'h10, 32'h52);
         wr(8'h20, 32'h01);
         wr(8'h14, 32'h5);
         chk("R8", "LSB first leading bit", {31'b0, spi_mosi}, 1);
         begin
            int g = 0;
            do begin rd(8'h00, "R2", v); g++; end while (v[0] && g < 2000);
         end
         chk("R9", "sck idle high", {31'b0, spi_sck}, 1);
         wr(8'h10, 32'h152);
         wr(8'h14, 32'h5);
         chk("R8", "MSB first leading bit", {31'b0, spi_mosi}, 0);
         begin
            int g = 0;
            do begin rd(8'h00, "R2", v); g++; end while (v[0] && g < 2000);
         end

         // R5/R8/R10 read LSB first, idle high, both edges falling
         wr(8'h10, 32'h72);
         run_xfer(32'h2, 4, 0, "R2");
         rd(8'h20, "R5", v);

         // R3 stop code holds the clock
         wr(8'h10, 32'h107);
         wr(8'h14, 32'h5);
         s0 = spi_sck;
         for (int k = 0; k < 40; k++) begin
            rd(8'h00, "R3", v);
            chk("R3", "busy held while stopped", {31'b0, v[0]}, 1);
            chk("R3", "sck frozen", {31'b0, spi_sck}, {31'b0, s0});
         end
         wr(8'h10, 32'h101);
         begin
            int g = 0;
            do begin rd(8'h00, "R3", v); g++; end while (v[0] && g < 2000);
         end
         chk("R3", "completes after restart", {31'b0, v[0]}, 0);

         // R7 active-high select, slowest divider
         wr(8'h10, 32'h10106);
         wr(8'h14, 32'h1);
         chk("R7", "active-high asserted", {31'b0, spi_cs}, 1);
         run_xfer(32'h5, 64, 0, "R3");
         wr(8'h14, 32'h0);
         chk("R7", "active-high released", {31'b0, spi_cs}, 0);
      end
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL R2 watchdog: got hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule